// File: doc/BRIEF.md
# Four-Channel Voice and Melody Mixer

The mixer combines four 8-bit audio channels into two DAC sample codes and a single pulse-width output. Every channel holds one sample byte written by the processor. In voice mode the channel plays that byte directly. In melody mode the channel becomes a square-wave tone. A tone flag flips on each underflow pulse from the timer tied to that channel. The channel plays its byte while the flag is high and the silence code while it is low.

Gang settings let one master channel supply the byte, mode and tone for two, three or four channels. This gives 1+1+1+1, 1+1+2, 1+3 and 2+2 groupings without the processor writing the same data into several registers. Samples are offset-binary: 80h is silence and FFh is full positive swing.

The first DAC mixes channels 1 and 2 and the second DAC mixes channels 3 and 4, unless merged mode is selected. The pulse-width output always mixes all four channels. Each of the three outputs has its own 4-bit volume.

Top module: `chan_mixer`

## Requirements
- R1: After reset, every register reads as zero. Both DAC codes are 00h, the pulse output is low, and all volumes are 0. Because the control register resets to zero, merged mode is selected.
- R2: Writes use a 4-bit select code: 0 to 3 pick the sample bytes of channels 1 to 4, 4 the play-mode register, 5 the audio control register, 6 the first DAC volume, 7 the second DAC volume and 8 the pulse volume. Select codes 9 to 15 change nothing.
- R3: When play-mode bit n (n = 0..3) is set, channel n+1 is in melody mode. Its tone flag flips on every cycle in which tick bit n is high, so the tone runs at half the tick rate. The channel outputs its byte while the flag is 1 and 80h while it is 0. In voice mode the flag is held at 0 and ticks have no effect.
- R4: irq_o bit n follows tick bit n in the same cycle, except that it is forced to 0 while play-mode bit n is set.
- R5: Play-mode bit 4 makes channel 2 copy channel 1 and channel 4 copy channel 3. A copying channel takes its byte, mode and tone state from its master and ignores its own.
- R6: Play-mode bit 5 makes channels 2 and 3 copy channel 1.
- R7: Play-mode bit 6 makes channel 3 copy channel 1. When bits 4 and 6 are both set, channel 4 follows channel 3 and therefore channel 1.
- R8: Play-mode bit 7 makes all four channels copy channel 1, whatever bits 4 to 6 hold.
- R9: With control bit 1 = 1 (separate), each DAC sums the offset-removed values of its own two channels. The sum is multiplied by that DAC's volume and divided by 15, truncating toward zero. The result is saturated to -128..127, and 80h is added back. The new code appears two clock edges after the register write.
- R10: With control bit 1 = 0 (merged), both DACs use the sum of all four channels, but each still applies its own volume.
- R11: Control bit 0 enables both DACs. While it is 0, both codes are 00h from the next cycle on.
- R12: Control bit 2 enables the pulse output. An 8-bit counter runs freely, and the output is high while the counter is below the all-channel sample scaled by the pulse volume. Over any 256 consecutive cycles the output is high for exactly that sample value. While the bit is 0 the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select code |
| reg_wdata | input | 8 | Write data |
| tick_i | input | 4 | Timer underflow pulses, one per channel |
| irq_o | output | 4 | Timer interrupts after melody suppression |
| dac1_o | output | 8 | First DAC sample code |
| dac2_o | output | 8 | Second DAC sample code |
| pwm_o | output | 1 | Pulse-width modulated mix |

## Verification
The hardest case to reach is a copying channel in melody mode. The channel's own tick and its own sample byte must both be shown to have no effect, yet the tone flag is only visible through the mixed DAC code. The stimulus first sets channel 1 to melody mode and checks its flag from the DAC level after single tick pulses. It then writes a loud byte into channel 2, turns on pairing, and shows that the DAC level follows only channel 1's tone while channel 2's ticks leave it unchanged. A table of gang and volume vectors chooses channel values that give a distinct DAC pair for every grouping, and it includes rounding of negative sums and saturation at both ends.

// File: rtl/chan_mix_pkg.sv
package chan_mix_pkg;
  localparam int NCH = 4;
  localparam int CTRL_W = 3;

  // register select codes
  localparam logic [3:0] SEL_DATA0 = 4'd0;
  localparam logic [3:0] SEL_MODE  = 4'd4;
  localparam logic [3:0] SEL_CTRL  = 4'd5;
  localparam logic [3:0] SEL_VOL1  = 4'd6;
  localparam logic [3:0] SEL_VOL2  = 4'd7;
  localparam logic [3:0] SEL_VOLP  = 4'd8;

  // control bit positions
  localparam int CB_DAC_EN = 0;
  localparam int CB_SPLIT  = 1;
  localparam int CB_PWM_EN = 2;

  // master channel index for each channel, from gang bits {b7,b6,b5,b4}
  function automatic logic [NCH-1:0][1:0] gang_src(input logic [3:0] g);
    logic [NCH-1:0][1:0] s;
    s[0] = 2'd0;
    s[1] = (g[3] | g[1] | g[0]) ? 2'd0 : 2'd1;
    s[2] = (g[3] | g[1] | g[2]) ? 2'd0 : 2'd2;
    s[3] = g[3] ? 2'd0 : (g[0] ? s[2] : 2'd3);
    return s;
  endfunction
endpackage

// File: rtl/chan_mix_regs.sv
module chan_mix_regs
  import chan_mix_pkg::*;
#(
  parameter int DW = 8,
  parameter int VW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [3:0]               sel,
  input  logic [DW-1:0]            wdata,
  output logic [NCH-1:0][DW-1:0]   data_q,
  output logic [7:0]               mode_q,
  output logic [CTRL_W-1:0]        ctrl_q,
  output logic [VW-1:0]            vol1_q,
  output logic [VW-1:0]            vol2_q,
  output logic [VW-1:0]            volp_q
);
  logic [NCH-1:0][DW-1:0] data_n;
  logic [7:0]             mode_n;
  logic [CTRL_W-1:0]      ctrl_n;
  logic [VW-1:0]          vol1_n, vol2_n, volp_n;

  always_comb begin
    data_n = data_q;
    mode_n = mode_q;
    ctrl_n = ctrl_q;
    vol1_n = vol1_q;
    vol2_n = vol2_q;
    volp_n = volp_q;
    if (we) begin
      for (int i = 0; i < NCH; i++)
        if (sel == SEL_DATA0 + 4'(i)) data_n[i] = wdata;
      if (sel == SEL_MODE) mode_n = wdata[7:0];
      if (sel == SEL_CTRL) ctrl_n = wdata[CTRL_W-1:0];
      if (sel == SEL_VOL1) vol1_n = wdata[VW-1:0];
      if (sel == SEL_VOL2) vol2_n = wdata[VW-1:0];
      if (sel == SEL_VOLP) volp_n = wdata[VW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mode_q <= '0;
      ctrl_q <= '0;
      vol1_q <= '0;
      vol2_q <= '0;
      volp_q <= '0;
    end else if (we) begin
      data_q <= data_n;
      mode_q <= mode_n;
      ctrl_q <= ctrl_n;
      vol1_q <= vol1_n;
      vol2_q <= vol2_n;
      volp_q <= volp_n;
    end
  end
endmodule

// File: rtl/chan_tone.sv
module chan_tone (
  input  logic clk,
  input  logic rst_n,
  input  logic melody,
  input  logic tick,
  output logic tgl_q
);
  logic tgl_n;

  always_comb begin
    tgl_n = melody ? (tgl_q ^ tick) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_n;
  end
endmodule

// File: rtl/chan_mix_core.sv
module chan_mix_core
  import chan_mix_pkg::*;
#(
  parameter int DW = 8,
  parameter int VW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0][DW-1:0] data_q,
  input  logic [7:0]             mode_q,
  input  logic [CTRL_W-1:0]      ctrl_q,
  input  logic [VW-1:0]          vol1_q,
  input  logic [VW-1:0]          vol2_q,
  input  logic [VW-1:0]          volp_q,
  input  logic [NCH-1:0]         tgl_q,
  output logic [DW-1:0]          dac1_q,
  output logic [DW-1:0]          dac2_q,
  output logic [DW-1:0]          psamp_q
);
  localparam int OFFS = 1 << (DW - 1);
  localparam int SMAX = OFFS - 1;
  localparam int SMIN = -OFFS;
  localparam int VMAX = (1 << VW) - 1;

  function automatic logic [DW-1:0] scale_sat(input int sum, input logic [VW-1:0] vol);
    int q;
    q = (sum * int'(vol)) / VMAX;
    if (q > SMAX) q = SMAX;
    if (q < SMIN) q = SMIN;
    return DW'(q + OFFS);
  endfunction

  logic [NCH-1:0][1:0]    src;
  logic [NCH-1:0][DW-1:0] own, eff;
  int                     sv [NCH];
  int                     sum_lo, sum_hi, sum_all;
  logic [DW-1:0]          dac1_n, dac2_n, psamp_n;

  always_comb begin
    src = gang_src(mode_q[7:4]);
    for (int i = 0; i < NCH; i++)
      own[i] = (mode_q[i] && !tgl_q[i]) ? DW'(OFFS) : data_q[i];
    for (int i = 0; i < NCH; i++) begin
      eff[i] = own[src[i]];
      sv[i]  = int'(eff[i]) - OFFS;
    end
    sum_lo  = sv[0] + sv[1];
    sum_hi  = sv[2] + sv[3];
    sum_all = sum_lo + sum_hi;
    if (ctrl_q[CB_DAC_EN]) begin
      dac1_n = scale_sat(ctrl_q[CB_SPLIT] ? sum_lo : sum_all, vol1_q);
      dac2_n = scale_sat(ctrl_q[CB_SPLIT] ? sum_hi : sum_all, vol2_q);
    end else begin
      dac1_n = '0;
      dac2_n = '0;
    end
    psamp_n = scale_sat(sum_all, volp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac1_q  <= '0;
      dac2_q  <= '0;
      psamp_q <= '0;
    end else begin
      dac1_q  <= dac1_n;
      dac2_q  <= dac2_n;
      psamp_q <= psamp_n;
    end
  end
endmodule

// File: rtl/chan_mix_pwm.sv
module chan_mix_pwm #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] samp,
  output logic          pwm_q
);
  logic [DW-1:0] cnt_q, cnt_n;
  logic          pwm_n;

  always_comb begin
    cnt_n = en ? cnt_q + 1'b1 : '0;
    pwm_n = en && (cnt_q < samp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      pwm_q <= pwm_n;
    end
  end
endmodule

// File: rtl/chan_mixer.sv
module chan_mixer
  import chan_mix_pkg::*;
#(
  parameter int DW = 8,
  parameter int VW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [3:0]     reg_sel,
  input  logic [DW-1:0]  reg_wdata,
  input  logic [3:0]     tick_i,
  output logic [3:0]     irq_o,
  output logic [DW-1:0]  dac1_o,
  output logic [DW-1:0]  dac2_o,
  output logic           pwm_o
);
  logic [1:0]             rst_sync_q;
  logic                   rst_ns;
  logic [NCH-1:0][DW-1:0] data_q;
  logic [7:0]             mode_q;
  logic [CTRL_W-1:0]      ctrl_q;
  logic [VW-1:0]          vol1_q, vol2_q, volp_q;
  logic [NCH-1:0]         tgl_q;
  logic [DW-1:0]          psamp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  chan_mix_regs #(.DW(DW), .VW(VW)) u_regs (
    .clk(clk), .rst_n(rst_ns), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .data_q(data_q), .mode_q(mode_q), .ctrl_q(ctrl_q),
    .vol1_q(vol1_q), .vol2_q(vol2_q), .volp_q(volp_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_tone
    chan_tone u_tone (
      .clk(clk), .rst_n(rst_ns), .melody(mode_q[i]), .tick(tick_i[i]), .tgl_q(tgl_q[i])
    );
  end

  assign irq_o = tick_i & ~mode_q[3:0];

  chan_mix_core #(.DW(DW), .VW(VW)) u_core (
    .clk(clk), .rst_n(rst_ns), .data_q(data_q), .mode_q(mode_q), .ctrl_q(ctrl_q),
    .vol1_q(vol1_q), .vol2_q(vol2_q), .volp_q(volp_q), .tgl_q(tgl_q),
    .dac1_q(dac1_o), .dac2_q(dac2_o), .psamp_q(psamp_q)
  );

  chan_mix_pwm #(.DW(DW)) u_pwm (
    .clk(clk), .rst_n(rst_ns), .en(ctrl_q[CB_PWM_EN]), .samp(psamp_q), .pwm_q(pwm_o)
  );
endmodule

// File: rtl/chan_mixer_chk.sv
module chan_mixer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    tick_i,
  input logic [3:0]    irq_o,
  input logic [3:0]    melody_q,
  input logic          dac_en_q,
  input logic          pwm_en_q,
  input logic [3:0]    tgl_q,
  input logic [DW-1:0] dac1_o,
  input logic [DW-1:0] dac2_o,
  input logic          pwm_o
);
  // R4
  irq_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & melody_q) == 4'b0000);

  // R11
  dac_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_en_q |=> (dac1_o == '0 && dac2_o == '0));

  // R12
  pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en_q |=> !pwm_o);

  // R3
  tone_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tgl_q ^ $past(tgl_q)) & $past(melody_q)) == $past(tick_i & melody_q));

  // R3
  tone_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tgl_q & ~$past(melody_q)) == 4'b0000);
endmodule

bind chan_mixer chan_mixer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_ns), .tick_i(tick_i), .irq_o(irq_o),
  .melody_q(mode_q[3:0]), .dac_en_q(ctrl_q[0]), .pwm_en_q(ctrl_q[2]),
  .tgl_q(tgl_q), .dac1_o(dac1_o), .dac2_o(dac2_o), .pwm_o(pwm_o)
);

// File: tb/chan_mixer_tb.sv
module chan_mixer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [3:0] reg_sel;
  logic [7:0] reg_wdata;
  logic [3:0] tick_i;
  logic [3:0] irq_o;
  logic [7:0] dac1_o, dac2_o;
  logic       pwm_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_mixer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .tick_i(tick_i), .irq_o(irq_o), .dac1_o(dac1_o), .dac2_o(dac2_o), .pwm_o(pwm_o)
  );

  // fields: mode, ctrl, vol1, vol2, volp, d1, d2, d3, d4, exp dac1, exp dac2
  localparam int NV = 11;
  localparam logic [87:0] VEC [NV] = '{
    {8'h00, 8'h03, 8'h0F, 8'h0F, 8'h0F, 8'h90, 8'hA0, 8'h70, 8'h88, 8'hB0, 8'h78}, // R9
    {8'h10, 8'h03, 8'h0F, 8'h0F, 8'h0F, 8'h90, 8'hA0, 8'h70, 8'h88, 8'hA0, 8'h60}, // R5
    {8'h20, 8'h03, 8'h0F, 8'h0F, 8'h0F, 8'h90, 8'hA0, 8'h70, 8'h88, 8'hA0, 8'h98}, // R6
    {8'h40, 8'h03, 8'h0F, 8'h0F, 8'h0F, 8'h90, 8'hA0, 8'h70, 8'h88, 8'hB0, 8'h98}, // R7
    {8'hF0, 8'h03, 8'h0F, 8'h0F, 8'h0F, 8'h90, 8'hA0, 8'h70, 8'h88, 8'hA0, 8'hA0}, // R8
    {8'h50, 8'h03, 8'h0F, 8'h0F, 8'h0F, 8'h90, 8'hA0, 8'h70, 8'h88, 8'hA0, 8'hA0}, // R7
    {8'h00, 8'h01, 8'h0F, 8'h05, 8'h0F, 8'h90, 8'hA0, 8'h70, 8'h88, 8'hA8, 8'h8D}, // R10
    {8'h00, 8'h03, 8'h0F, 8'h04, 8'h0F, 8'hFF, 8'hFF, 8'h70, 8'h88, 8'hFF, 8'h7E}, // R9
    {8'h00, 8'h03, 8'h0F, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h10, 8'h00, 8'h80}, // R9
    {8'h00, 8'h02, 8'h0F, 8'h0F, 8'h0F, 8'h90, 8'hA0, 8'h70, 8'h88, 8'h00, 8'h00}, // R11
    {8'h80, 8'h01, 8'h03, 8'h0F, 8'h0F, 8'h90, 8'hA0, 8'h70, 8'h88, 8'h8C, 8'hC0}  // R8
  };

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic tk(input logic [3:0] m);
    @(negedge clk);
    tick_i = m;
    @(negedge clk);
    tick_i = 4'b0000;
    settle();
  endtask

  task automatic pwm_count(output int n);
    n = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (pwm_o) n++;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0; tick_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 dac1", dac1_o, 8'h00);
    chk("R1 dac2", dac2_o, 8'h00);
    chk("R1 pwm", pwm_o, 0);
    tick_i = 4'b1000; #1;
    chk("R1 irq", irq_o, 4'b1000);
    @(negedge clk); tick_i = 4'b0000;

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr(4'd4, VEC[v][87:80]);
      wr(4'd5, VEC[v][79:72]);
      wr(4'd6, VEC[v][71:64]);
      wr(4'd7, VEC[v][63:56]);
      wr(4'd8, VEC[v][55:48]);
      wr(4'd0, VEC[v][47:40]);
      wr(4'd1, VEC[v][39:32]);
      wr(4'd2, VEC[v][31:24]);
      wr(4'd3, VEC[v][23:16]);
      settle();
      chk($sformatf("R2 vec%0d dac1", v), dac1_o, VEC[v][15:8]);
      chk($sformatf("R2 vec%0d dac2", v), dac2_o, VEC[v][7:0]);
    end

    // R2 unused select codes
    wr(4'd9, 8'hFF);
    wr(4'd15, 8'h00);
    settle();
    chk("R2 unused sel dac1", dac1_o, 8'h8C);
    chk("R2 unused sel dac2", dac2_o, 8'hC0);

    // R3 melody tone
    wr(4'd5, 8'h03); wr(4'd6, 8'h0F); wr(4'd7, 8'h0F);
    wr(4'd0, 8'h90); wr(4'd1, 8'h80); wr(4'd2, 8'h80); wr(4'd3, 8'h80);
    wr(4'd4, 8'h01);
    settle();
    chk("R3 tone low", dac1_o, 8'h80);
    tk(4'b0001);
    chk("R3 tone high", dac1_o, 8'h90);
    tk(4'b0010);
    chk("R3 voice tick no effect", dac1_o, 8'h90);
    tk(4'b0001);
    chk("R3 tone low again", dac1_o, 8'h80);

    // R5 copier follows master tone
    wr(4'd1, 8'hF0);
    wr(4'd4, 8'h11);
    settle();
    chk("R5 copy silent", dac1_o, 8'h80);
    tk(4'b0001);
    chk("R5 copy tone", dac1_o, 8'hA0);
    tk(4'b0010);
    chk("R5 own tick ignored", dac1_o, 8'hA0);

    // R4 irq suppression
    @(negedge clk); tick_i = 4'b0011; #1;
    chk("R4 irq melody", irq_o, 4'b0010);
    @(negedge clk); tick_i = 4'b0000;
    wr(4'd4, 8'h00);
    @(negedge clk); tick_i = 4'b0001; #1;
    chk("R4 irq voice", irq_o, 4'b0001);
    @(negedge clk); tick_i = 4'b0000;

    // R12 pwm
    wr(4'd5, 8'h05); wr(4'd8, 8'h0F);
    wr(4'd0, 8'h90); wr(4'd1, 8'h90); wr(4'd2, 8'h90); wr(4'd3, 8'h90);
    settle();
    pwm_count(n);
    chk("R12 duty full vol", n, 192);
    wr(4'd8, 8'h08);
    settle();
    pwm_count(n);
    chk("R12 duty vol8", n, 162);
    wr(4'd5, 8'h01);
    settle();
    pwm_count(n);
    chk("R12 disabled", n, 0);

    // R1 reset in mid run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset dac1", dac1_o, 8'h00);
    chk("R1 mid reset pwm", pwm_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(4'd5, 8'h01);
    settle();
    chk("R1 volume cleared dac1", dac1_o, 8'h80);
    chk("R1 volume cleared dac2", dac2_o, 8'h80);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule